// File: doc/BRIEF.md
# Dual-Lane Multiply-With-Carry Random Word Generator

This block produces a stream of 32-bit pseudo-random words from two independent 16-bit multiply-with-carry lanes, called Z and W. Each lane holds a 32-bit state. On an advance, a lane multiplies the lower 16 bits of its state by a fixed multiplier and adds the upper 16 bits. The sum, taken modulo 2^32, is the new state. The Z lane uses the multiplier 36969 and the W lane uses 18000.

The output word is the fresh Z state shifted up by 16 bits, plus the fresh W state, truncated to 32 bits. It is registered together with a one-cycle valid flag. A consumer pulses `adv_i` once for each word it wants and takes `rnd_o` when `rnd_vld_o` is high. Reducing the word to a range is left to the consumer.

A seed port loads both lanes at once. A lane refuses a seed that would lock it at a fixed point:
- Zero is refused by both lanes.
- 0x9068FFFF is also refused by Z.
- 0x464FFFFF is also refused by W.

A refused lane keeps its old state, and an error flag pulses for one cycle. Reset restores the fixed default seeds.

Top module: `mwc_rng`

## Requirements
- R1: In a cycle with `rst_i` high, the state returns to the defaults Z = 0x05080902 and W = 0xABABAB55. On the cycle after, `rnd_o` = 0, `rnd_vld_o` = 0 and `seed_err_o` = 0. The first word produced after reset comes from these default seeds.
- R2: On each advance, the Z lane's new state is 36969 * Z[15:0] + Z[31:16], modulo 2^32.
- R3: On each advance, the W lane's new state is 18000 * W[15:0] + W[31:16], modulo 2^32.
- R4: The output word is (Znew << 16) + Wnew, truncated to 32 bits. It is formed from the states just produced by the same advance.
- R5: A clock edge that samples `adv_i` high and `seed_ld_i` low makes `rnd_vld_o` high for exactly the following cycle. `rnd_vld_o` is never high without such a preceding edge. An advance held high on N consecutive edges yields N consecutive valid words.
- R6: While `rnd_vld_o` is low, `rnd_o` keeps the last word produced.
- R7: When `seed_ld_i` is sampled high, each lane whose seed is legal takes that seed (`seed_z_i` for Z, `seed_w_i` for W) as its new state. Later words continue from the loaded states.
- R8: A lane refuses a seed of 0. Z also refuses 0x9068FFFF, and W also refuses 0x464FFFFF. A refused lane keeps its previous state, while the other lane still loads if its own seed is legal. `seed_err_o` is high for exactly the one cycle after a load that had any refused seed, and low after a fully legal load.
- R9: When `seed_ld_i` and `adv_i` are high in the same cycle, the load takes effect and the advance is ignored: no valid word follows, and `rnd_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe: one word per sampled high |
| seed_ld_i | input | 1 | Seed load strobe; has priority over the advance strobe |
| seed_z_i | input | 32 | Seed for lane Z |
| seed_w_i | input | 32 | Seed for lane W |
| rnd_o | output | 32 | Last generated random word |
| rnd_vld_o | output | 1 | High for one cycle when a new word is in `rnd_o` |
| seed_err_o | output | 1 | High for one cycle after a load containing a refused seed |

## Verification
The assertions check on every cycle:
- the valid pulse follows only an accepted advance;
- the output word is consistent with the two updated lane states;
- the word holds between pulses;
- the error flag follows only a load;
- neither lane ever holds zero.

Only the bench scenarios can show that the numeric recurrence is right. The bench does this by comparing the first thousand words from the default seeds, and further runs after reloads, against a model in the bench. The scenarios also show that a refused seed really leaves that lane's state untouched, and that the load-over-advance priority leaves the sequence aligned.

// File: rtl/mwc_pkg.sv
package mwc_pkg;

    localparam int WORD_W = 32;
    localparam int HALF_W = WORD_W / 2;

    localparam logic [HALF_W-1:0] Z_MULT = 16'd36969;
    localparam logic [HALF_W-1:0] W_MULT = 16'd18000;

    localparam logic [WORD_W-1:0] Z_DEFAULT = 32'h0508_0902;
    localparam logic [WORD_W-1:0] W_DEFAULT = 32'hABAB_AB55;

    localparam logic [WORD_W-1:0] Z_STUCK = 32'h9068_FFFF;
    localparam logic [WORD_W-1:0] W_STUCK = 32'h464F_FFFF;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } op_e;

    typedef struct packed {
        word_t z;
        word_t w;
    } lanes_t;

    // one multiply-with-carry step: mult * low half + high half, mod 2^WORD_W
    function automatic word_t mwc_step(input word_t s, input half_t mult);
        word_t prod;
        prod = {{HALF_W{1'b0}}, s[HALF_W-1:0]} * {{HALF_W{1'b0}}, mult};
        return prod + {{HALF_W{1'b0}}, s[WORD_W-1:HALF_W]};
    endfunction

    function automatic logic seed_legal(input word_t s, input word_t stuck);
        return (s != '0) && (s != stuck);
    endfunction

    function automatic word_t mix_word(input lanes_t l);
        return (l.z << HALF_W) + l.w;
    endfunction

endpackage

// File: rtl/mwc_ctrl.sv
module mwc_ctrl
    import mwc_pkg::*;
(
    input  logic adv_i,
    input  logic seed_ld_i,
    output op_e  op_o
);
    always_comb begin
        if (seed_ld_i)      op_o = OP_LOAD;
        else if (adv_i)     op_o = OP_STEP;
        else                op_o = OP_IDLE;
    end
endmodule

// File: rtl/mwc_lane.sv
module mwc_lane
    import mwc_pkg::*;
#(
    parameter half_t MULT    = Z_MULT,
    parameter word_t DEFSEED = Z_DEFAULT,
    parameter word_t STUCK   = Z_STUCK
) (
    input  logic  clk_i,
    input  logic  rst_i,
    input  op_e   op_i,
    input  word_t seed_i,
    output word_t state_o,
    output word_t next_o,
    output logic  refuse_o
);
    word_t state_q;

    assign next_o   = mwc_step(state_q, MULT);
    assign refuse_o = !seed_legal(seed_i, STUCK);
    assign state_o  = state_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= DEFSEED;
        end else begin
            case (op_i)
                OP_STEP: state_q <= next_o;
                OP_LOAD: if (!refuse_o) state_q <= seed_i;
                default: state_q <= state_q;
            endcase
        end
    end
endmodule

// File: rtl/mwc_rng.sv
module mwc_rng
    import mwc_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        adv_i,
    input  logic        seed_ld_i,
    input  logic [31:0] seed_z_i,
    input  logic [31:0] seed_w_i,
    output logic [31:0] rnd_o,
    output logic        rnd_vld_o,
    output logic        seed_err_o
);
    op_e    op;
    lanes_t state, nxt;
    logic   ref_z, ref_w;
    word_t  rnd_q;
    logic   vld_q, err_q;

    mwc_ctrl ctrl_i (
        .adv_i     (adv_i),
        .seed_ld_i (seed_ld_i),
        .op_o      (op)
    );

    mwc_lane #(.MULT(Z_MULT), .DEFSEED(Z_DEFAULT), .STUCK(Z_STUCK)) lane_z_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .seed_i   (seed_z_i),
        .state_o  (state.z),
        .next_o   (nxt.z),
        .refuse_o (ref_z)
    );

    mwc_lane #(.MULT(W_MULT), .DEFSEED(W_DEFAULT), .STUCK(W_STUCK)) lane_w_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .op_i     (op),
        .seed_i   (seed_w_i),
        .state_o  (state.w),
        .next_o   (nxt.w),
        .refuse_o (ref_w)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rnd_q <= '0;
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= (op == OP_STEP);
            err_q <= (op == OP_LOAD) && (ref_z || ref_w);
            if (op == OP_STEP) rnd_q <= mix_word(nxt);
        end
    end

    assign rnd_o      = rnd_q;
    assign rnd_vld_o  = vld_q;
    assign seed_err_o = err_q;
endmodule

// File: rtl/mwc_rng_chk.sv
module mwc_rng_chk (
    input logic        clk_i,
    input logic        rst_i,
    input logic        adv_i,
    input logic        seed_ld_i,
    input logic [31:0] rnd_o,
    input logic        rnd_vld_o,
    input logic        seed_err_o,
    input logic [31:0] z_q,
    input logic [31:0] w_q
);
    AST_VLD_AFTER_ADV: assert property (@(posedge clk_i) disable iff (rst_i)
        (adv_i && !seed_ld_i) |=> rnd_vld_o); // R5

    AST_VLD_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (rst_i)
        (rnd_vld_o && !$past(rst_i)) |-> $past(adv_i && !seed_ld_i)); // R5

    AST_WORD_FROM_LANES: assert property (@(posedge clk_i) disable iff (rst_i)
        rnd_vld_o |-> (rnd_o == ((z_q << 16) + w_q))); // R4

    AST_WORD_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
        (!rnd_vld_o && !$past(rst_i)) |-> $stable(rnd_o)); // R6

    AST_ERR_FROM_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
        (seed_err_o && !$past(rst_i)) |-> $past(seed_ld_i)); // R8

    AST_LOAD_BLOCKS_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        seed_ld_i |=> !rnd_vld_o); // R9

    AST_Z_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (z_q != 32'd0)); // R8

    AST_W_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (w_q != 32'd0)); // R8
endmodule

bind mwc_rng mwc_rng_chk chk_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .adv_i      (adv_i),
    .seed_ld_i  (seed_ld_i),
    .rnd_o      (rnd_o),
    .rnd_vld_o  (rnd_vld_o),
    .seed_err_o (seed_err_o),
    .z_q        (state.z),
    .w_q        (state.w)
);

// File: tb/mwc_rng_tb_top.sv
`timescale 1ns/1ps
module mwc_rng_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adv = 1'b0;
    logic        ld  = 1'b0;
    logic [31:0] sz  = '0;
    logic [31:0] sw  = '0;
    logic [31:0] rnd;
    logic        vld;
    logic        err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] mz, mw, last_word;
    logic [31:0] exp_q[$];

    always #2 clk = ~clk;

    mwc_rng dut_i (
        .clk_i(clk), .rst_i(rst), .adv_i(adv), .seed_ld_i(ld),
        .seed_z_i(sz), .seed_w_i(sw),
        .rnd_o(rnd), .rnd_vld_o(vld), .seed_err_o(err)
    );

    function automatic logic [31:0] step(input logic [31:0] s, input logic [31:0] m);
        return m * {16'd0, s[15:0]} + {16'd0, s[31:16]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // driver: advance n consecutive cycles, pushing expected words
    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin
            adv = 1'b1;
            mz = step(mz, 32'd36969);
            mw = step(mw, 32'd18000);
            last_word = (mz << 16) + mw;
            exp_q.push_back(last_word);
            @(negedge clk);
        end
        adv = 1'b0;
    endtask

    task automatic load(input logic [31:0] z, input logic [31:0] w, input bit with_adv, input string tag);
        bit bz, bw;
        bz = (z == 0) || (z == 32'h9068FFFF);
        bw = (w == 0) || (w == 32'h464FFFFF);
        ld = 1'b1; sz = z; sw = w; adv = with_adv;
        if (!bz) mz = z;
        if (!bw) mw = w;
        @(negedge clk);
        ld = 1'b0; adv = 1'b0;
        chk(err == (bz || bw), {tag, " seed_err"}, {31'd0, err}, {31'd0, bz || bw});
        chk(vld == 1'b0, {tag, " no word on load"}, {31'd0, vld}, 32'd0);
        chk(rnd == last_word, {tag, " word unchanged on load"}, rnd, last_word);
        @(negedge clk);
        chk(err == 1'b0, "R8 seed_err one cycle", {31'd0, err}, 32'd0);
    endtask

    // monitor: pop and compare each produced word
    always @(negedge clk) begin
        if (!rst && vld) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected valid", rnd, 32'd0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(rnd == e, "R2 R3 R4 word sequence", rnd, e);
            end
        end
    end

    task automatic idle_check(input int n);
        repeat (n) @(negedge clk);
        chk(vld == 1'b0, "R5 valid drops", {31'd0, vld}, 32'd0);
        chk(rnd == last_word, "R6 word held", rnd, last_word);
        chk(exp_q.size() == 0, "R5 every advance produced", exp_q.size(), 32'd0);
    endtask

    initial begin
        mz = 32'h05080902;
        mw = 32'hABABAB55;
        last_word = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(rnd == 0, "R1 reset word", rnd, 32'd0);
        chk(vld == 0, "R1 reset valid", {31'd0, vld}, 32'd0);
        chk(err == 0, "R1 reset seed_err", {31'd0, err}, 32'd0);

        // R1 R2 R3 R4: first thousand words from the defaults, back to back
        advance(1000);
        idle_check(3);

        // R5: isolated single advances with gaps
        for (int k = 0; k < 5; k++) begin
            advance(1);
            idle_check(k + 1);
        end

        // R7: legal load then sequence
        load(32'h12345678, 32'h9ABCDEF1, 1'b0, "R7 legal");
        advance(50);
        idle_check(2);

        // R8: refused seeds, each lane and both
        load(32'h0, 32'h0BADF00D, 1'b0, "R8 zero z");
        advance(20);
        idle_check(1);
        load(32'h13579BDF, 32'h464FFFFF, 1'b0, "R8 stuck w");
        advance(20);
        idle_check(1);
        load(32'h9068FFFF, 32'h0, 1'b0, "R8 both refused");
        advance(20);
        idle_check(1);
        load(32'h464FFFFF, 32'h9068FFFF, 1'b0, "R8 cross values legal");
        advance(20);
        idle_check(1);

        // R9: load and advance together
        load(32'hCAFEBABE, 32'h01020304, 1'b1, "R9 load wins");
        advance(30);
        idle_check(2);

        // R1: reset mid-stream restores defaults
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mz = 32'h05080902;
        mw = 32'hABABAB55;
        last_word = '0;
        @(negedge clk);
        chk(rnd == 0, "R1 reset word again", rnd, 32'd0);
        advance(10);
        idle_check(2);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule